// File: doc/BRIEF.md
# Dual-Core Reset and Secondary Boot Controller

This block is a word-wide register file that sits in a 4 KB address window. It drives reset and power control for two processor cores. Software asks for a core reset by flipping that core's bit in the core-reset register. The block sends a one-cycle reset pulse to that core. The bit then stays at its written value until the core reports completion on its reset-done input, and at that point the block clears it.

A second register holds the enable state of the secondary core. When its enable bit changes, the block does one of two things:
- A change to one sends a one-cycle power-on request. The request carries the boot entry address and a context value, taken from two of the general-purpose registers.
- A change to zero sends a one-cycle power-off request.

The same reset-done input of the secondary core clears its reset bit after either transition. Every other register is plain storage.

Top module: `core_reset_ctrl`

## Requirements
- R1: After reset every register reads zero except three: word 0 reads 0xA0, word 9 reads 0x1 and word 11 reads 0x1F.
- R2: The register index is the byte address shifted right by two, and the bus has 23 words (indices 0 to 22). An aligned write to an in-range index stores the data, and a later read of that index returns it. A write to any index other than 1 and 2 causes no pulse on any output.
- R3: A read returns zero when its index is 23 or more, or when address bits [1:0] are not zero. A write to such an address changes no register and causes no pulse.
- R4: When word 1 is written, core c gets a reset pulse if bit c of the write data differs from bit c of the stored value (c = 0 or 1). The pulse is high on coreRstPulse[c] for exactly the one cycle after the write edge. A core whose bit is unchanged gets no pulse.
- R5: A write to word 1 stores the full written value. Bit c of word 1 is then cleared to zero at the clock edge that samples coreRstDone[c] high.
- R6: When a write to word 1 and coreRstDone[c] fall on the same edge, bit c ends at zero whatever the write data holds for it.
- R7: A write to word 2 that changes bit 1 from 0 to 1 pulses core1PowerOn for one cycle. In that same cycle core1EntryAddr shows the value of word 15 and core1Context shows the value of word 16, both as they stood before the write.
- R8: A write to word 2 that changes bit 1 from 1 to 0 pulses core1PowerOff for one cycle. A write that leaves bit 1 unchanged pulses neither output. Either transition is finished by coreRstDone[1], which clears bit 1 of word 1 as in R5.
- R9: core1EntryAddr and core1Context hold their values until the next power-on request, even if words 15 and 16 are rewritten in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| coreRstDone | input | 2 | Per-core reset/transition complete acknowledge |
| coreRstPulse | output | 2 | Per-core one-cycle reset request |
| core1PowerOn | output | 1 | One-cycle secondary power-on request |
| core1PowerOff | output | 1 | One-cycle secondary power-off request |
| core1EntryAddr | output | 32 | Boot entry address for the secondary core |
| core1Context | output | 32 | Boot context value for the secondary core |

## Verification
The bench targets these corner cases of the core-reset register:
- Writing back the same value to word 1. A design that triggered on written ones instead of on changes would pulse here.
- Clearing a bit by writing zero. A design that triggered on written ones would miss this reset.
- A write that lands on the same edge as a reset-done acknowledge. A design with the wrong priority would leave the reset bit stuck at one.

On the secondary core, the bench covers these cases:
- Rewriting words 15 and 16 after launch. A design that passes the registers straight through would let the boot outputs drift.
- Rewriting word 2 with an unchanged enable bit. A design that decodes the level instead of the change would send a spurious power request.
- Misaligned and out-of-range accesses. A decoder that ignores the low address bits, or that wraps the index, would corrupt a real register here.

// File: rtl/core_reset_pkg.sv
package core_reset_pkg;
  localparam int NCORES        = 2;
  localparam int CTRL_IDX      = 0;
  localparam int CORE_RST_IDX  = 1;
  localparam int CORE_EN_IDX   = 2;
  localparam int STATUS_IDX    = 9;
  localparam int IMASK_IDX     = 11;
  localparam int BOOT_ADDR_IDX = 15;
  localparam int BOOT_CTX_IDX  = 16;
  localparam int SEC_EN_BIT    = 1;

  localparam logic [31:0] CTRL_RST   = 32'h0000_00A0;
  localparam logic [31:0] STATUS_RST = 32'h0000_0001;
  localparam logic [31:0] IMASK_RST  = 32'h0000_001F;

  typedef struct packed {
    logic              hit;
    logic              wrEn;
    logic [NCORES-1:0] rstReq;
    logic              pwrOn;
    logic              pwrOff;
  } strobe_t;
endpackage

// File: rtl/core_reset_ctl.sv
module core_reset_ctl
  import core_reset_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NCORES-1:0]   curRst,
  input  logic                curEn,
  output logic [ADDR_W-3:0]   regIdx,
  output strobe_t             stb,
  output logic [NCORES-1:0]   coreRstPulse,
  output logic                core1PowerOn,
  output logic                core1PowerOff
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] RST_SEL  = IDX_W'(CORE_RST_IDX);
  localparam logic [IDX_W-1:0] EN_SEL   = IDX_W'(CORE_EN_IDX);

  logic wrAny;

  assign regIdx  = busAddr[ADDR_W-1:2];
  assign stb.hit = (busAddr[1:0] == 2'b00) && (regIdx <= LAST_IDX);
  assign wrAny   = busSel && busWrite && stb.hit;
  assign stb.wrEn = wrAny;

  for (genvar c = 0; c < NCORES; c++) begin : g_rstReq
    assign stb.rstReq[c] = wrAny && (regIdx == RST_SEL) && (busWdata[c] != curRst[c]);
  end

  assign stb.pwrOn  = wrAny && (regIdx == EN_SEL) && (busWdata[SEC_EN_BIT] != curEn) &&  busWdata[SEC_EN_BIT];
  assign stb.pwrOff = wrAny && (regIdx == EN_SEL) && (busWdata[SEC_EN_BIT] != curEn) && !busWdata[SEC_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreRstPulse  <= '0;
      core1PowerOn  <= 1'b0;
      core1PowerOff <= 1'b0;
    end else begin
      coreRstPulse  <= stb.rstReq;
      core1PowerOn  <= stb.pwrOn;
      core1PowerOff <= stb.pwrOff;
    end
  end
endmodule

// File: rtl/core_reset_dp.sv
module core_reset_dp
  import core_reset_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-3:0]   regIdx,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NCORES-1:0]   coreRstDone,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NCORES-1:0]   curRst,
  output logic                curEn,
  output logic [DATA_W-1:0]   core1EntryAddr,
  output logic [DATA_W-1:0]   core1Context
);
  localparam int RIDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [RIDX_W-1:0] slot;

  assign slot = regIdx[RIDX_W-1:0];

  function automatic logic [DATA_W-1:0] resetValue(int i);
    case (i)
      CTRL_IDX:   return DATA_W'(CTRL_RST);
      STATUS_IDX: return DATA_W'(STATUS_RST);
      IMASK_IDX:  return DATA_W'(IMASK_RST);
      default:    return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= resetValue(i);
      core1EntryAddr <= '0;
      core1Context   <= '0;
    end else begin
      if (stb.wrEn) regs[slot] <= busWdata;
      // acknowledge clears after the write so it wins on the same edge
      for (int c = 0; c < NCORES; c++)
        if (coreRstDone[c]) regs[CORE_RST_IDX][c] <= 1'b0;
      if (stb.pwrOn) begin
        core1EntryAddr <= regs[BOOT_ADDR_IDX];
        core1Context   <= regs[BOOT_CTX_IDX];
      end
    end
  end

  assign curRst   = regs[CORE_RST_IDX][NCORES-1:0];
  assign curEn    = regs[CORE_EN_IDX][SEC_EN_BIT];
  assign busRdata = stb.hit ? regs[slot] : '0;
endmodule

// File: rtl/core_reset_ctrl.sv
module core_reset_ctrl
  import core_reset_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [1:0]        coreRstDone,
  output logic [1:0]        coreRstPulse,
  output logic              core1PowerOn,
  output logic              core1PowerOff,
  output logic [DATA_W-1:0] core1EntryAddr,
  output logic [DATA_W-1:0] core1Context
);
  strobe_t           stb;
  logic [ADDR_W-3:0] regIdx;
  logic [NCORES-1:0] curRst;
  logic              curEn;

  core_reset_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .curRst(curRst), .curEn(curEn),
    .regIdx(regIdx), .stb(stb), .coreRstPulse(coreRstPulse),
    .core1PowerOn(core1PowerOn), .core1PowerOff(core1PowerOff)
  );

  core_reset_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .stb(stb), .busWdata(busWdata),
    .coreRstDone(coreRstDone), .busRdata(busRdata), .curRst(curRst),
    .curEn(curEn), .core1EntryAddr(core1EntryAddr), .core1Context(core1Context)
  );
endmodule

// File: rtl/core_reset_ctrl_chk.sv
module core_reset_ctrl_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [1:0]        coreRstDone,
  input logic [1:0]        coreRstPulse,
  input logic              core1PowerOn,
  input logic              core1PowerOff,
  input logic [DATA_W-1:0] core1EntryAddr,
  input logic [DATA_W-1:0] core1Context
);
  logic rstWrite, badAddr;
  assign rstWrite = busSel && busWrite && (busAddr == ADDR_W'(4));
  assign badAddr  = (busAddr[1:0] != 2'b00) || (busAddr[ADDR_W-1:2] > (ADDR_W-2)'(NUM_REGS - 1));

  // R4
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreRstPulse != 2'b00) |-> $past(rstWrite));

  // R3
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    badAddr |-> (busRdata == '0));

  // R3
  bad_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && badAddr) |=> (coreRstPulse == 2'b00 && !core1PowerOn && !core1PowerOff));

  // R8
  pwr_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(core1PowerOn && core1PowerOff));

  // R9
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !core1PowerOn |-> ($stable(core1EntryAddr) && $stable(core1Context)));
endmodule

bind core_reset_ctrl core_reset_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uChk (.*);

// File: tb/tb_core_reset_ctrl.sv
`timescale 1ns/1ps
module tb_core_reset_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWrite = 0;
  logic [11:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [1:0]  coreRstDone = 0;
  logic [1:0]  coreRstPulse;
  logic        core1PowerOn, core1PowerOff;
  logic [31:0] core1EntryAddr, core1Context;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  logic [31:0] model [23];
  logic [1:0]  expPulse;
  logic        expOn, expOff;
  logic [31:0] expEntry, expCtx;

  always #2.5 clk = ~clk;

  core_reset_ctrl dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .coreRstDone(coreRstDone), .coreRstPulse(coreRstPulse),
    .core1PowerOn(core1PowerOn), .core1PowerOff(core1PowerOff),
    .core1EntryAddr(core1EntryAddr), .core1Context(core1Context)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit hitOf(logic [11:0] a);
    return (a[1:0] == 2'b00) && ((a >> 2) < 23);
  endfunction

  // one bus cycle: drive after negedge, compare read, step model, compare outputs
  task automatic step(bit sel, bit wr, logic [11:0] a, logic [31:0] d, logic [1:0] done);
    int idx;
    logic [31:0] chg;
    busSel = sel; busWrite = wr; busAddr = a; busWdata = d; coreRstDone = done;
    idx = int'(a >> 2);
    #1;
    if (hitOf(a)) check("R2 read", busRdata, model[idx]);
    else          check("R3 bad read", busRdata, 32'h0);
    expPulse = 2'b00; expOn = 0; expOff = 0;
    if (sel && wr && hitOf(a)) begin
      if (idx == 1) begin
        chg = model[1] ^ d;
        expPulse = chg[1:0];
      end else if (idx == 2 && (model[2][1] != d[1])) begin
        if (d[1]) begin
          expOn = 1; expEntry = model[15]; expCtx = model[16];
        end else expOff = 1;
      end
      model[idx] = d;
    end
    for (int c = 0; c < 2; c++) if (done[c]) model[1][c] = 1'b0;
    @(posedge clk); #1;
    check("R4 pulse", {30'h0, coreRstPulse}, {30'h0, expPulse});
    check("R7 power-on", {31'h0, core1PowerOn}, {31'h0, expOn});
    check("R8 power-off", {31'h0, core1PowerOff}, {31'h0, expOff});
    check("R9 entry", core1EntryAddr, expEntry);
    check("R9 context", core1Context, expCtx);
    @(negedge clk);
    busSel = 0; busWrite = 0; coreRstDone = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] done = 2'b00);
    step(1, 1, a, d, done);
  endtask

  task automatic rd(logic [11:0] a);
    step(1, 0, a, 32'h0, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < 23; i++) model[i] = 0;
    model[0] = 32'hA0; model[9] = 32'h1; model[11] = 32'h1F;
    expEntry = 0; expCtx = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset values of every word
    for (int i = 0; i < 23; i++) rd(12'(i * 4));
    check("R1 ctrl", model[0], 32'hA0);
    // R2 plain storage, no side effect
    for (int i = 13; i < 23; i++) wr(12'(i * 4), 32'h1000_0000 + 32'(i));
    for (int i = 13; i < 23; i++) rd(12'(i * 4));
    wr(12'h000, 32'hDEAD_BEEF); rd(12'h000);
    // R3 out-of-range and misaligned
    rd(12'h05C); rd(12'hFFC); rd(12'h002);
    wr(12'h05C, 32'hFFFF_FFFF); wr(12'h036, 32'h1234_5678); rd(12'h034);
    // R4/R5 core reset by change
    wr(12'h004, 32'h0000_0001); rd(12'h004);
    wr(12'h004, 32'h0000_0001);              // same value, no pulse
    step(0, 0, 12'h004, 0, 2'b01); rd(12'h004); // R5 ack clears bit 0
    wr(12'h004, 32'h0000_0003);               // core0 0->1, core1 0->1
    wr(12'h004, 32'h0000_0002);               // core0 1->0 pulse
    step(0, 0, 12'h004, 0, 2'b10); rd(12'h004);
    wr(12'h004, 32'h0000_0000);               // no change
    // R6 write and ack on the same edge
    wr(12'h004, 32'hF000_0003, 2'b11); rd(12'h004);
    wr(12'h004, 32'hF000_0001, 2'b01); rd(12'h004);
    step(0, 0, 12'h004, 0, 2'b11);
    // R7 power on with entry/context from words 15 and 16
    wr(12'h03C, 32'h8000_1000); wr(12'h040, 32'h0000_00C7);
    wr(12'h008, 32'h0000_0002);
    // R9 hold after rewriting the boot words
    wr(12'h03C, 32'h1111_1111); wr(12'h040, 32'h2222_2222); rd(12'h03C);
    wr(12'h008, 32'h0000_0003);               // R8 bit1 unchanged
    // R8 power off, then ack clears core1 reset bit
    wr(12'h004, 32'h0000_0002);
    wr(12'h008, 32'h0000_0001);
    step(0, 0, 12'h004, 0, 2'b10); rd(12'h004);
    wr(12'h008, 32'h0000_0002);               // R7 relaunch with new words
    rd(12'h008);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule